// File: doc/BRIEF.md
# Clock-Monitored Power State Controller

This controller chooses the power state of an audio converter without any register interface. It runs from a free-running reference clock and watches three things: whether the master clock is toggling, whether the bit clock is toggling, and the level of an unmute control pin. From these it keeps one of three states: Off, Standby or Enabled. It drives a charge-pump enable and a datapath enable from that state.

Leaving Enabled is done quietly. The controller first raises a soft-mute request while the datapath stays powered. It disables the datapath only when the audio side answers with a done pulse, or when a ramp timeout expires if no answer comes. Standby is sticky: once the block is there, losing the bit clock does not move it, as long as the master clock keeps running. Losing the master clock forces Off from any state.

A separate monitor counts rising edges of the frame clock (the left/right word clock of the serial audio link). It raises a warning when two sample-rate changes come closer together than a configurable number of frame periods. That warning recommends moving to Standby.

All inputs here are plain control levels or pulses. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset the state is Off, and the charge-pump enable, datapath enable, soft-mute request and rate warning are all 0.
- R2: A clock counts as running once a rising edge of it has been seen. It stays running until CLK_TIMEOUT reference cycles pass with no rising edge. Outputs react to a clock loss only after that window, and never within 8 reference cycles of the last edge when CLK_TIMEOUT is 16.
- R3: From Off, when the master clock and the bit clock both run and the filtered unmute level is 1, the state becomes Enabled (charge pump 1, datapath 1, request 0). With only the master clock running, the state stays Off.
- R4: From Off, when both clocks run and the filtered unmute level is 0, the state becomes Standby (charge pump 1, datapath 0).
- R5: In Standby with the master clock running, the state stays Standby unless unmute is 1 and the bit clock runs. In particular, losing the bit clock keeps Standby.
- R6: Standby moves to Enabled only when unmute is 1 and the bit clock is running.
- R7: In Enabled, unmute going to 0 or the bit clock stopping enters a ramp phase first. In the ramp phase the request is 1 and the charge pump and datapath stay 1. A done input then leads to Standby (datapath 0, charge pump 1, request 0).
- R8: If done does not arrive within RAMP_TIMEOUT reference cycles of the ramp phase, the state moves to Standby anyway.
- R9: When the master clock stops running, the state is forced to Off from any state, including the ramp phase, and every output goes to 0.
- R10: The unmute pin passes through a two-flop synchronizer and then a debounce filter. A level change takes effect only after it has held for DEB_CYCLES consecutive reference cycles, so shorter pulses have no effect.
- R11: A sample-rate change pulse raises the rate warning when fewer than RATE_WINDOW frame-clock rising edges have passed since the previous change; at reset the edge count starts saturated. The warning clears while the datapath is disabled (Off or Standby).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mclk_in | input | 1 | Master clock, asynchronous, monitored for activity |
| bclk_in | input | 1 | Bit clock, asynchronous, monitored for activity |
| lrclk_in | input | 1 | Frame clock, asynchronous, rising edges counted |
| unmute_in | input | 1 | Unmute pin, asynchronous; 1 allows audio, 0 requests mute |
| rate_chg_in | input | 1 | One-cycle pulse in the reference domain marking a sample-rate change |
| smute_done_in | input | 1 | Soft-mute ramp has finished |
| cp_en_o | output | 1 | Charge-pump enable |
| dp_en_o | output | 1 | Analog/datapath enable |
| smute_req_o | output | 1 | Soft-mute request |
| rate_warn_o | output | 1 | Rate changes too frequent; Standby recommended |

## Verification
The bench builds the block with CLK_TIMEOUT=16, DEB_CYCLES=4, RAMP_TIMEOUT=20 and RATE_WINDOW=8. With these values, a clock-loss window, a debounce boundary, a ramp timeout and a rate window each last only tens of reference cycles. That makes it practical to sweep every unmute pulse length from 1 to 7 cycles, which spans both sides of the debounce boundary. It also allows every gap from 1 to 12 frame periods between two rate changes, which spans both sides of the rate window. The expected outcomes are computed arithmetically from the pulse length and the gap.

// File: rtl/pwr_ctrl_pkg.sv
package pwr_ctrl_pkg;
  typedef enum logic [1:0] {
    PS_OFF     = 2'd0,
    PS_STANDBY = 2'd1,
    PS_ACTIVE  = 2'd2,
    PS_RAMP    = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/edge_sync.sv
module edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [2:0] sq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sq <= '0;
    else        sq <= {sq[1:0], async_in};
  end

  assign rise_o = sq[1] & ~sq[2];
endmodule

// File: rtl/clk_activity_det.sv
module clk_activity_det #(
  parameter int TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_clk,
  output logic running_o
);
  localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LIM = CW'(TIMEOUT - 1);

  logic          rise;
  logic [CW-1:0] idle_q;
  logic          run_q;

  edge_sync u_sync (.clk(clk), .rst_n(rst_n), .async_in(mon_clk), .rise_o(rise));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= LIM;
      run_q  <= 1'b0;
    end else if (rise) begin
      idle_q <= '0;
      run_q  <= 1'b1;
    end else if (idle_q == LIM) begin
      run_q  <= 1'b0;
    end else begin
      idle_q <= idle_q + 1'b1;
    end
  end

  assign running_o = run_q;

  AST_RUN_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> run_q); // R2
  AST_DROP_ONLY_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> $past(idle_q) == LIM); // R2
endmodule

// File: rtl/mute_filter.sv
module mute_filter #(
  parameter int DEB = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic level_o
);
  localparam int CW = (DEB > 2) ? $clog2(DEB) : 1;
  localparam logic [CW-1:0] LIM = CW'(DEB - 1);

  logic [1:0]    sync_q;
  logic          filt_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], pin_in};
      if (sync_q[1] == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == LIM) begin
        filt_q <= sync_q[1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level_o = filt_q;

  AST_FILT_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> $past(sync_q[1]) == filt_q); // R10
  AST_FILT_AFTER_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> $past(cnt_q) == LIM); // R10
endmodule

// File: rtl/rate_change_mon.sv
module rate_change_mon #(
  parameter int WINDOW = 1026
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_rise,
  input  logic chg_i,
  input  logic clr_i,
  output logic warn_o
);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] WIN = CW'(WINDOW);

  logic [CW-1:0] gap_q;
  logic          warn_q;
  logic          close_chg;

  assign close_chg = chg_i && (gap_q < WIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= WIN;
      warn_q <= 1'b0;
    end else begin
      if (chg_i)                        gap_q <= '0;
      else if (frame_rise && gap_q < WIN) gap_q <= gap_q + 1'b1;
      if (clr_i)          warn_q <= 1'b0;
      else if (close_chg) warn_q <= 1'b1;
    end
  end

  assign warn_o = warn_q;

  AST_WARN_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_q) |-> $past(chg_i)); // R11
  AST_WARN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !warn_q); // R11
  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= WIN); // R11
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_ctrl_pkg::*;
#(
  parameter int RAMP_TMO = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mclk_run,
  input  logic       bclk_run,
  input  logic       unmute,
  input  logic       ramp_done,
  output pwr_state_e state_o
);
  localparam int TW = (RAMP_TMO > 2) ? $clog2(RAMP_TMO) : 1;
  localparam logic [TW-1:0] TLIM = TW'(RAMP_TMO - 1);

  pwr_state_e state_q, state_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          play_ok;

  assign play_ok = unmute && bclk_run;

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    if (!mclk_run) begin
      state_d = PS_OFF;
      tmr_d   = '0;
    end else begin
      unique case (state_q)
        PS_OFF: begin
          if (bclk_run) state_d = unmute ? PS_ACTIVE : PS_STANDBY;
        end
        PS_STANDBY: begin
          if (play_ok) state_d = PS_ACTIVE;
        end
        PS_ACTIVE: begin
          if (!play_ok) begin
            state_d = PS_RAMP;
            tmr_d   = '0;
          end
        end
        PS_RAMP: begin
          if (ramp_done || tmr_q == TLIM) state_d = PS_STANDBY;
          else                            tmr_d   = tmr_q + 1'b1;
        end
        default: state_d = PS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_OFF;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
    end
  end

  assign state_o = state_q;

  AST_MCLK_LOSS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !mclk_run |=> state_q == PS_OFF); // R9
  AST_STANDBY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_STANDBY && mclk_run && !play_ok) |=> state_q == PS_STANDBY); // R5
  AST_EXIT_VIA_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_ACTIVE && mclk_run && !play_ok) |=> state_q == PS_RAMP); // R7
  AST_NO_DIRECT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_ACTIVE) |=> state_q != PS_STANDBY); // R7
  AST_RAMP_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_RAMP && tmr_q == TLIM && mclk_run) |=> state_q == PS_STANDBY); // R8
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_ctrl_pkg::*;
#(
  parameter int CLK_TIMEOUT  = 64,
  parameter int DEB_CYCLES   = 8,
  parameter int RAMP_TIMEOUT = 4096,
  parameter int RATE_WINDOW  = 1026
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic mclk_in,
  input  logic bclk_in,
  input  logic lrclk_in,
  input  logic unmute_in,
  input  logic rate_chg_in,
  input  logic smute_done_in,
  output logic cp_en_o,
  output logic dp_en_o,
  output logic smute_req_o,
  output logic rate_warn_o
);
  localparam int NCLK = 2;

  logic [NCLK-1:0] mon_in;
  logic [NCLK-1:0] run;
  logic            unmute_f;
  logic            frame_rise;
  pwr_state_e      state;

  assign mon_in = {bclk_in, mclk_in};

  for (genvar g = 0; g < NCLK; g++) begin : g_act
    clk_activity_det #(.TIMEOUT(CLK_TIMEOUT)) u_det (
      .clk(clk_ref), .rst_n(rst_n), .mon_clk(mon_in[g]), .running_o(run[g])
    );
  end

  mute_filter #(.DEB(DEB_CYCLES)) u_mute (
    .clk(clk_ref), .rst_n(rst_n), .pin_in(unmute_in), .level_o(unmute_f)
  );

  edge_sync u_frame (
    .clk(clk_ref), .rst_n(rst_n), .async_in(lrclk_in), .rise_o(frame_rise)
  );

  pwr_fsm #(.RAMP_TMO(RAMP_TIMEOUT)) u_fsm (
    .clk(clk_ref), .rst_n(rst_n), .mclk_run(run[0]), .bclk_run(run[1]),
    .unmute(unmute_f), .ramp_done(smute_done_in), .state_o(state)
  );

  always_comb begin
    cp_en_o     = (state != PS_OFF);
    dp_en_o     = (state == PS_ACTIVE) || (state == PS_RAMP);
    smute_req_o = (state == PS_RAMP);
  end

  rate_change_mon #(.WINDOW(RATE_WINDOW)) u_rate (
    .clk(clk_ref), .rst_n(rst_n), .frame_rise(frame_rise),
    .chg_i(rate_chg_in), .clr_i(!dp_en_o), .warn_o(rate_warn_o)
  );

  AST_DP_NEEDS_CP: assert property (@(posedge clk_ref) disable iff (!rst_n)
    dp_en_o |-> cp_en_o); // R7
  AST_REQ_WITH_DP: assert property (@(posedge clk_ref) disable iff (!rst_n)
    smute_req_o |-> dp_en_o); // R7
endmodule

// File: tb/test_pwr_state_ctrl.sv
module test_pwr_state_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mclk = 1'b0, bclk = 1'b0, lrclk = 1'b0;
  logic unmute = 1'b0, rate_chg = 1'b0, smute_done = 1'b0;
  logic cp_en, dp_en, smute_req, rate_warn;
  bit mclk_on = 0, bclk_on = 0;
  bit auto_done = 0, man_done = 0, prev_req = 0, finished = 0;
  int ramps = 0;
  int n_chk = 0, n_err = 0;

  localparam int WIN = 8;
  localparam int DEB = 4;

  pwr_state_ctrl #(.CLK_TIMEOUT(16), .DEB_CYCLES(DEB), .RAMP_TIMEOUT(20),
                   .RATE_WINDOW(WIN)) i_pwr_state_ctrl (
    .clk_ref(clk), .rst_n(rst_n), .mclk_in(mclk), .bclk_in(bclk),
    .lrclk_in(lrclk), .unmute_in(unmute), .rate_chg_in(rate_chg),
    .smute_done_in(smute_done), .cp_en_o(cp_en), .dp_en_o(dp_en),
    .smute_req_o(smute_req), .rate_warn_o(rate_warn)
  );

  always #2 clk = ~clk;
  initial forever begin #8;  if (mclk_on) mclk = ~mclk; else mclk = 1'b0; end
  initial forever begin #12; if (bclk_on) bclk = ~bclk; else bclk = 1'b0; end
  initial forever begin #20; lrclk = ~lrclk; end

  initial forever begin
    @(negedge clk);
    smute_done = (auto_done && smute_req) || man_done;
    if (smute_req && !prev_req) ramps++;
    prev_req = smute_req;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int outs();
    return {cp_en, dp_en, smute_req};
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    cyc(3);
    chk(outs() == 0 && rate_warn == 0, "R1", outs(), 0);
    rst_n = 1'b1;
    cyc(30);
    chk(outs() == 0 && rate_warn == 0, "R1", outs(), 0);

    // R3: master clock only keeps Off, then both clocks with unmute=1
    unmute = 1'b1;
    mclk_on = 1;
    cyc(40);
    chk(outs() == 0, "R3", outs(), 0);
    bclk_on = 1;
    cyc(40);
    chk(outs() == 3'b110, "R3", outs(), 3'b110);

    // R2 / R7 / R8: bit clock loss, no done -> ramp, then timeout
    bclk_on = 0;
    cyc(8);
    chk(outs() == 3'b110, "R2", outs(), 3'b110);
    cyc(19);
    chk(outs() == 3'b111, "R7", outs(), 3'b111);
    cyc(33);
    chk(outs() == 3'b100, "R8", outs(), 3'b100);

    // R5 / R6: standby sticky without bit clock, enables when it returns
    cyc(10);
    chk(outs() == 3'b100, "R5", outs(), 3'b100);
    bclk_on = 1;
    cyc(40);
    chk(outs() == 3'b110, "R6", outs(), 3'b110);

    // R10: sweep unmute low pulse lengths around the debounce limit
    auto_done = 1;
    for (int len = 1; len <= 7; len++) begin
      int r0;
      r0 = ramps;
      unmute = 1'b0;
      cyc(len);
      unmute = 1'b1;
      cyc(30);
      chk(ramps - r0 == ((len >= DEB) ? 1 : 0), "R10", ramps - r0, (len >= DEB) ? 1 : 0);
      chk(outs() == 3'b110, "R10", outs(), 3'b110);
    end

    // R7: mute -> request held until done, then standby
    auto_done = 0;
    unmute = 1'b0;
    cyc(12);
    chk(outs() == 3'b111, "R7", outs(), 3'b111);
    man_done = 1;
    cyc(3);
    man_done = 0;
    cyc(3);
    chk(outs() == 3'b100, "R7", outs(), 3'b100);
    unmute = 1'b1;
    cyc(20);
    chk(outs() == 3'b110, "R6", outs(), 3'b110);

    // R11: sweep gaps between two rate changes
    auto_done = 1;
    for (int gap = 1; gap <= 12; gap++) begin
      repeat (10) @(posedge lrclk);
      cyc(6);
      rate_chg = 1'b1;
      cyc(1);
      rate_chg = 1'b0;
      cyc(2);
      chk(rate_warn == 0, "R11", rate_warn, 0);
      repeat (gap) @(posedge lrclk);
      cyc(6);
      rate_chg = 1'b1;
      cyc(1);
      rate_chg = 1'b0;
      cyc(3);
      chk(rate_warn == (gap < WIN), "R11", rate_warn, (gap < WIN) ? 1 : 0);
      unmute = 1'b0;
      cyc(25);
      chk(rate_warn == 0 && outs() == 3'b100, "R11", rate_warn, 0);
      unmute = 1'b1;
      cyc(20);
    end

    // R9: master clock loss during ramp forces Off
    auto_done = 0;
    unmute = 1'b0;
    cyc(10);
    chk(outs() == 3'b111, "R9", outs(), 3'b111);
    mclk_on = 0;
    cyc(40);
    chk(outs() == 0, "R9", outs(), 0);

    // R4: Off -> Standby with unmute=0
    mclk_on = 1;
    cyc(40);
    chk(outs() == 3'b100, "R4", outs(), 3'b100);
    mclk_on = 0;
    cyc(40);
    chk(outs() == 0, "R9", outs(), 0);

    summary();
  end
endmodule